// File: doc/BRIEF.md
# Configuration Space Register File

This block holds the 256-byte configuration image of a single bridge-type function. A configuration agent reaches it through a request port. Each request carries a 24-bit address holding the bus number, the combined device/function number and the byte offset, together with a size code and, for writes, a data word. A read returns its little-endian data on the cycle after the request, marked by a response strobe. A read to a foreign bus or slot, or one that runs past the end of the space, returns all ones. A write is applied byte by byte. The identity bytes and the header-type byte cannot be written, and the base-address bytes change only through aligned full-word writes.

A full-word write to a base-address register keeps only the address bits that its region size allows. For the expansion ROM base, bit 0 (the enable bit) is also kept. A write to any base-address register, or a write whose byte range covers any byte of the 16-bit command register, produces a one-cycle remap strobe for the address-decode logic. The block also holds a shadow copy of the secondary bus number, taken from the bridge bus-number bytes.

Top module: `cfgsp_top`

## Requirements
- R1: After reset the image reads back vendor ID (param, offset 0x00), device ID (param, 0x02), command 0x0006, status low byte 0xA0 (0x06), sub-class 0x04 (0x0A), base class 0x06 (0x0B), latency timer 0x10 (0x0D), header type 0x81 (0x0E), secondary status 0xA0 (0x1E), and zero in every other byte.
- R2: A read request produces rsp_valid on the following cycle and on no other. A write request never produces rsp_valid.
- R3: Read data is little-endian: the byte at the offset sits in bits [7:0], and the following bytes sit in higher lanes. For 1-byte and 2-byte reads the unused upper bits are zero. Size codes are 0 for 1 byte, 1 for 2 bytes and 2 for 4 bytes.
- R4: A 4-byte access above offset 0xFC, a 2-byte access above 0xFE, or size code 3 is out of range. Such a read returns 0xFFFFFFFF, and such a write changes nothing.
- R5: Only requests whose address bits [23:16] equal BUS and bits [15:8] equal DEVFN are served. Any other read returns 0xFFFFFFFF, and any other write changes nothing.
- R6: Writes to bytes 0x00-0x03, 0x08-0x0B and 0x0E are ignored.
- R7: A 4-byte write at a 4-aligned offset in 0x10-0x27 (region n = (offset-0x10)/4) stores data AND NOT(2^REGION_LOG2[n]-1).
- R8: A 4-byte write at offset 0x30 stores data AND NOT(2^REGION_LOG2[6]-1), with bit 0 of the data kept.
- R9: Any other write (1 or 2 bytes, or an unaligned 4-byte write) leaves bytes 0x10-0x27 and 0x30-0x33 unchanged.
- R10: One cycle after an accepted write whose byte range covers offset 0x04 or 0x05, or after a base-address write from R7 or R8, remap_pulse is high for that cycle. It is low after every other request and after idle cycles.
- R11: An accepted write at offset 0x19 sets sec_bus to data[7:0]. An accepted 2-byte or 4-byte write at offset 0x18 sets sec_bus to data[15:8]. Nothing else changes sec_bus, which is 0 after reset.
- R12: All bytes not covered by R6 and R9 hold the data written by 1-, 2- or 4-byte writes, including unaligned ones, until they are written again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 24 | {bus, devfn, offset} |
| req_size | input | 2 | 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = invalid |
| req_wdata | input | 32 | Write data, little-endian |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| remap_pulse | output | 1 | One-cycle mapping-update strobe |
| sec_bus | output | 8 | Secondary bus number shadow |

## Verification
Writes are tried at aligned and unaligned offsets and at all three sizes. They show whether each byte lands in the correct lane and whether protected bytes survive. Full-word writes of all ones and of mixed patterns go to regions of different sizes and to the ROM slot, with bit 0 both set and clear. These separate the size mask from the kept enable bit. Writes that straddle the command register from either side, or sit just beside it, show whether the overlap test is exact. Reads at the last legal offset and one past it, and requests to a foreign bus or slot, check the all-ones answers.

// File: rtl/cfgsp_pkg.sv
package cfgsp_pkg;

    localparam int CFG_BYTES = 256;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_BAD  = 2'd3
    } acc_size_e;

    typedef logic [CFG_BYTES-1:0][7:0] cfg_image_t;

    typedef struct packed {
        cfg_image_t  mem;
        logic        rsp_valid;
        logic [31:0] rdata;
        logic        remap;
        logic [7:0]  sec_bus;
    } cfg_state_t;

    function automatic cfg_image_t reset_image(logic [15:0] ven, logic [15:0] dev);
        cfg_image_t img;
        img        = '0;
        img[8'h00] = ven[7:0];
        img[8'h01] = ven[15:8];
        img[8'h02] = dev[7:0];
        img[8'h03] = dev[15:8];
        img[8'h04] = 8'h06;
        img[8'h06] = 8'hA0;
        img[8'h0A] = 8'h04;
        img[8'h0B] = 8'h06;
        img[8'h0D] = 8'h10;
        img[8'h0E] = 8'h81;
        img[8'h1E] = 8'hA0;
        return img;
    endfunction

    function automatic logic is_identity(logic [7:0] a);
        return (a <= 8'h03) || (a >= 8'h08 && a <= 8'h0B) || (a == 8'h0E);
    endfunction

    function automatic logic is_bar_byte(logic [7:0] a);
        return (a >= 8'h10 && a <= 8'h27) || (a >= 8'h30 && a <= 8'h33);
    endfunction

endpackage

// File: rtl/cfgsp_decode.sv
module cfgsp_decode
    import cfgsp_pkg::*;
#(
    parameter logic [7:0] BUS   = 8'h00,
    parameter logic [7:0] DEVFN = 8'h10
) (
    input  logic [23:0] addr,
    input  logic [1:0]  size,
    output logic        hit,
    output logic [7:0]  off,
    output logic [2:0]  nbytes,
    output logic        in_range,
    output logic        bar_wr,
    output logic [2:0]  bar_idx,
    output logic        cmd_touch,
    output logic        sb_hit,
    output logic        sb_from_hi
);
    localparam logic [7:0] CMD_LO = 8'h04;
    localparam logic [7:0] CMD_HI = 8'h05;

    logic [8:0] last;
    logic [7:0] rel;

    always_comb begin
        hit = (addr[23:16] == BUS) && (addr[15:8] == DEVFN);
        off = addr[7:0];
        unique case (acc_size_e'(size))
            SZ_BYTE: begin nbytes = 3'd1; in_range = 1'b1; end
            SZ_HALF: begin nbytes = 3'd2; in_range = (off <= 8'hFE); end
            SZ_WORD: begin nbytes = 3'd4; in_range = (off <= 8'hFC); end
            default: begin nbytes = 3'd0; in_range = 1'b0; end
        endcase
        last      = {1'b0, off} + {6'd0, nbytes} - 9'd1;
        cmd_touch = (nbytes != 3'd0) && (off <= CMD_HI) && (last >= {1'b0, CMD_LO});
        rel       = off - 8'h10;
        bar_wr    = (nbytes == 3'd4) && (off[1:0] == 2'b00) && is_bar_byte(off);
        bar_idx   = (off >= 8'h30) ? 3'd6 : rel[4:2];
        sb_from_hi = (off == 8'h18) && (nbytes > 3'd1);
        sb_hit     = (off == 8'h19) || sb_from_hi;
    end
endmodule

// File: rtl/cfgsp_lanes.sv
module cfgsp_lanes
    import cfgsp_pkg::*;
#(
    parameter int       LANES       = 4,
    parameter logic [6:0][4:0] REGION_LOG2 = {5'd11, 5'd4, 5'd4, 5'd4, 5'd12, 5'd8, 5'd4}
) (
    input  logic [7:0]              off,
    input  logic [2:0]              nbytes,
    input  logic                    bar_wr,
    input  logic [2:0]              bar_idx,
    input  logic [8*LANES-1:0]      wdata,
    output logic [LANES-1:0]        we,
    output logic [LANES-1:0][7:0]   addr,
    output logic [LANES-1:0][7:0]   data
);
    localparam logic [2:0] ROM_IDX = 3'd6;

    logic [4:0]         lg;
    logic [31:0]        mask;
    logic [8*LANES-1:0] word;

    always_comb begin
        lg   = (bar_idx > ROM_IDX) ? 5'd0 : REGION_LOG2[bar_idx];
        mask = ~((32'd1 << lg) - 32'd1);
        if (bar_idx == ROM_IDX) mask[0] = 1'b1;
        word = bar_wr ? (wdata & mask[8*LANES-1:0]) : wdata;
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        always_comb begin
            addr[i] = off + 8'(i);
            data[i] = word[8*i +: 8];
            we[i]   = (3'(i) < nbytes) &&
                      (bar_wr || (!is_identity(addr[i]) && !is_bar_byte(addr[i])));
        end
    end
endmodule

// File: rtl/cfgsp_top.sv
module cfgsp_top
    import cfgsp_pkg::*;
#(
    parameter logic [7:0]       BUS         = 8'h00,
    parameter logic [7:0]       DEVFN       = 8'h10,
    parameter logic [15:0]      VENDOR_ID   = 16'hCAFE,
    parameter logic [15:0]      DEVICE_ID   = 16'h0B12,
    parameter logic [6:0][4:0]  REGION_LOG2 = {5'd11, 5'd4, 5'd4, 5'd4, 5'd12, 5'd8, 5'd4}
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic [23:0] req_addr,
    input  logic [1:0]  req_size,
    input  logic [31:0] req_wdata,
    output logic        rsp_valid,
    output logic [31:0] rsp_rdata,
    output logic        remap_pulse,
    output logic [7:0]  sec_bus
);
    localparam int LANES = 4;

    logic                  hit, in_range, bar_wr, cmd_touch, sb_hit, sb_from_hi;
    logic [7:0]            off;
    logic [2:0]            nbytes, bar_idx;
    logic [LANES-1:0]      lane_we;
    logic [LANES-1:0][7:0] lane_addr, lane_data;

    cfgsp_decode #(.BUS(BUS), .DEVFN(DEVFN)) u_dec (
        .addr      (req_addr),
        .size      (req_size),
        .hit       (hit),
        .off       (off),
        .nbytes    (nbytes),
        .in_range  (in_range),
        .bar_wr    (bar_wr),
        .bar_idx   (bar_idx),
        .cmd_touch (cmd_touch),
        .sb_hit    (sb_hit),
        .sb_from_hi(sb_from_hi)
    );

    cfgsp_lanes #(.LANES(LANES), .REGION_LOG2(REGION_LOG2)) u_lanes (
        .off    (off),
        .nbytes (nbytes),
        .bar_wr (bar_wr),
        .bar_idx(bar_idx),
        .wdata  (req_wdata),
        .we     (lane_we),
        .addr   (lane_addr),
        .data   (lane_data)
    );

    cfg_state_t  st_d, st_q;
    logic        rd_req, wr_ok;
    logic [31:0] rd_word;

    always_comb begin
        st_d   = st_q;
        rd_req = req_valid && !req_write;
        wr_ok  = req_valid && req_write && hit && in_range;

        rd_word = '0;
        for (int i = 0; i < LANES; i++) begin
            if (3'(i) < nbytes) rd_word[8*i +: 8] = st_q.mem[off + 8'(i)];
        end

        st_d.rsp_valid = rd_req;
        if (rd_req) st_d.rdata = (hit && in_range) ? rd_word : 32'hFFFF_FFFF;

        st_d.remap = wr_ok && (cmd_touch || bar_wr);
        if (wr_ok) begin
            for (int i = 0; i < LANES; i++) begin
                if (lane_we[i]) st_d.mem[lane_addr[i]] = lane_data[i];
            end
            if (sb_hit) st_d.sec_bus = sb_from_hi ? req_wdata[15:8] : req_wdata[7:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.mem       <= reset_image(VENDOR_ID, DEVICE_ID);
            st_q.rsp_valid <= 1'b0;
            st_q.rdata     <= '0;
            st_q.remap     <= 1'b0;
            st_q.sec_bus   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_valid   = st_q.rsp_valid;
    assign rsp_rdata   = st_q.rdata;
    assign remap_pulse = st_q.remap;
    assign sec_bus     = st_q.sec_bus;
endmodule

// File: rtl/cfgsp_checker.sv
module cfgsp_checker #(
    parameter logic [7:0] BUS   = 8'h00,
    parameter logic [7:0] DEVFN = 8'h10
) (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_write,
    input logic [23:0] req_addr,
    input logic [1:0]  req_size,
    input logic        rsp_valid,
    input logic [31:0] rsp_rdata,
    input logic        remap_pulse,
    input logic [7:0]  sec_bus
);
    a_r2_read_answers: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> rsp_valid);

    a_r2_write_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write) |=> !rsp_valid);

    a_r5_foreign_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && (req_addr[23:16] != BUS || req_addr[15:8] != DEVFN))
        |=> (rsp_rdata == 32'hFFFF_FFFF));

    a_r4_bad_size_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && req_size == 2'd3) |=> (rsp_rdata == 32'hFFFF_FFFF));

    a_r10_remap_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        remap_pulse |-> $past(req_valid && req_write));

    a_r11_secbus_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_write) |=> $stable(sec_bus));
endmodule

bind cfgsp_top cfgsp_checker #(.BUS(BUS), .DEVFN(DEVFN)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_size   (req_size),
    .rsp_valid  (rsp_valid),
    .rsp_rdata  (rsp_rdata),
    .remap_pulse(remap_pulse),
    .sec_bus    (sec_bus)
);

// File: tb/cfgsp_top_test.sv
`timescale 1ns/1ps
module cfgsp_top_test;
    localparam logic [7:0] MY_BUS = 8'h00;
    localparam logic [7:0] MY_DF  = 8'h10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [23:0] req_addr = '0;
    logic [1:0]  req_size = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid, remap_pulse;
    logic [31:0] rsp_rdata;
    logic [7:0]  sec_bus;

    always #4 clk = ~clk;

    cfgsp_top uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .remap_pulse(remap_pulse), .sec_bus(sec_bus)
    );

    int mdl [256];
    int sec_exp;
    int lg_tab [7] = '{4, 8, 12, 4, 4, 4, 11};
    int n_chk = 0, n_fail = 0;
    bit done = 0;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic int sz_len(int sz);
        return (sz == 0) ? 1 : (sz == 1) ? 2 : (sz == 2) ? 4 : 0;
    endfunction

    function automatic bit legal(int off, int len);
        if (len == 0) return 0;
        return (off + len) <= 256;
    endfunction

    function automatic bit protected_byte(int a);
        if (a <= 3 || (a >= 8 && a <= 11) || a == 14) return 1;
        if ((a >= 16 && a <= 39) || (a >= 48 && a <= 51)) return 1;
        return 0;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 256; i++) mdl[i] = 0;
        mdl[0] = 'hFE; mdl[1] = 'hCA; mdl[2] = 'h12; mdl[3] = 'h0B;
        mdl[4] = 'h06; mdl[6] = 'hA0; mdl[10] = 'h04; mdl[11] = 'h06;
        mdl[13] = 'h10; mdl[14] = 'h81; mdl[30] = 'hA0;
        sec_exp = 0;
    endtask

    // one request cycle, then compare on the next negedge
    task automatic access(bit wr, logic [7:0] bus, logic [7:0] df, int off, int sz,
                          logic [31:0] wd, string tag);
        int len = sz_len(sz);
        bit ok = (bus == MY_BUS) && (df == MY_DF) && legal(off, len);
        logic [31:0] exp_rd = 32'hFFFF_FFFF;
        bit exp_remap = 0;
        req_valid = 1; req_write = wr; req_addr = {bus, df, 8'(off)};
        req_size = 2'(sz); req_wdata = wd;
        if (!wr && ok) begin
            exp_rd = 0;
            for (int i = 0; i < len; i++) exp_rd[8*i +: 8] = 8'(mdl[off + i]);
        end
        if (wr && ok) begin
            bit barw = (len == 4) && (off % 4 == 0) &&
                       ((off >= 16 && off < 40) || (off >= 48 && off < 52));
            logic [31:0] v = wd;
            if (barw) begin
                int idx = (off >= 48) ? 6 : (off - 16) / 4;
                v = wd & ~((32'd1 << lg_tab[idx]) - 1);
                if (idx == 6) v[0] = wd[0];
                exp_remap = 1;
            end
            if (off <= 5 && off + len - 1 >= 4) exp_remap = 1;
            for (int i = 0; i < len; i++)
                if (barw || !protected_byte(off + i)) mdl[off + i] = int'(v[8*i +: 8]);
            if (off == 'h19) sec_exp = int'(wd[7:0]);
            if (off == 'h18 && len > 1) sec_exp = int'(wd[15:8]);
        end
        @(negedge clk);
        req_valid = 0; req_write = 0;
        chk("R2 rsp_valid", {31'd0, rsp_valid}, {31'd0, !wr});
        if (!wr) chk(tag, rsp_rdata, exp_rd);
        chk("R10 remap_pulse", {31'd0, remap_pulse}, {31'd0, exp_remap});
        chk("R11 sec_bus", {24'd0, sec_bus}, 32'(sec_exp));
    endtask

    task automatic rd(int off, int sz, string tag);
        access(0, MY_BUS, MY_DF, off, sz, 0, tag);
    endtask
    task automatic wr(int off, int sz, logic [31:0] d, string tag);
        access(1, MY_BUS, MY_DF, off, sz, d, tag);
    endtask

    task automatic idle();
        @(negedge clk);
        chk("R2 idle rsp_valid", {31'd0, rsp_valid}, 32'd0);
        chk("R10 idle remap", {31'd0, remap_pulse}, 32'd0);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (4) @(negedge clk);
        rst_n = 1;
        idle();
        // R1 reset image
        chk("R1 sec_bus reset", {24'd0, sec_bus}, 32'd0);
        rd('h00, 2, "R1 ids");      chk("R1 ids literal", rsp_rdata, 32'h0B12_CAFE);
        rd('h04, 1, "R1 command");  chk("R1 command literal", rsp_rdata, 32'h0000_0006);
        rd('h08, 2, "R1 class");    chk("R1 class literal", rsp_rdata, 32'h0604_0000);
        rd('h0C, 2, "R1 hdr");      chk("R1 hdr literal", rsp_rdata, 32'h0081_1000);
        rd('h1C, 2, "R1 secstat");  chk("R1 secstat literal", rsp_rdata, 32'h00A0_0000);
        rd('h80, 2, "R1 zero");
        // R3 little-endian lanes, R12 writable bytes
        wr('h40, 2, 32'h1122_3344, "R12 word");
        rd('h40, 0, "R3 byte0");    chk("R3 byte0 literal", rsp_rdata, 32'h44);
        rd('h41, 0, "R3 byte1");
        rd('h42, 1, "R3 half");     chk("R3 half literal", rsp_rdata, 32'h1122);
        rd('h41, 2, "R3 unaligned word"); chk("R3 unaligned literal", rsp_rdata, 32'h0011_2233);
        wr('h3D, 1, 32'hFFFF_A55A, "R12 unaligned half");
        rd('h3C, 2, "R12 readback");
        wr('h0C, 1, 32'h0000_2008, "R12 latency");
        rd('h0C, 2, "R12 latency readback");
        idle();
        // R6 identity bytes
        wr('h00, 2, 32'hFFFF_FFFF, "R6 ids");
        rd('h00, 2, "R6 ids kept"); chk("R6 ids literal", rsp_rdata, 32'h0B12_CAFE);
        wr('h0E, 0, 32'h0, "R6 header");
        rd('h0E, 0, "R6 header kept"); chk("R6 header literal", rsp_rdata, 32'h81);
        wr('h09, 1, 32'hFFFF, "R6 class");
        rd('h08, 2, "R6 class kept");
        // R7 base address masking
        wr('h10, 2, 32'hFFFF_FFFF, "R7 bar0");
        rd('h10, 2, "R7 bar0 rb");  chk("R7 bar0 literal", rsp_rdata, 32'hFFFF_FFF0);
        wr('h14, 2, 32'h1234_5678, "R7 bar1");
        rd('h14, 2, "R7 bar1 rb");  chk("R7 bar1 literal", rsp_rdata, 32'h1234_5600);
        wr('h18, 2, 32'hFFFF_FFFF, "R7 bar2");
        rd('h18, 2, "R7 bar2 rb");  chk("R7 bar2 literal", rsp_rdata, 32'hFFFF_F000);
        wr('h24, 2, 32'h8765_4321, "R7 bar5");
        rd('h24, 2, "R7 bar5 rb");
        // R8 ROM enable kept
        wr('h30, 2, 32'hABCD_E7FF, "R8 rom set");
        rd('h30, 2, "R8 rom rb");   chk("R8 rom literal", rsp_rdata, 32'hABCD_E001);
        wr('h30, 2, 32'hFFFF_FFFE, "R8 rom clear");
        rd('h30, 2, "R8 rom rb2");  chk("R8 rom literal2", rsp_rdata, 32'hFFFF_F800);
        // R9 partial writes to base bytes
        wr('h10, 0, 32'h0, "R9 byte");
        wr('h14, 1, 32'h0, "R9 half");
        wr('h12, 2, 32'h0, "R9 unaligned word");
        wr('h32, 1, 32'h0, "R9 rom half");
        rd('h10, 2, "R9 bar0 kept"); chk("R9 bar0 literal", rsp_rdata, 32'hFFFF_FFF0);
        rd('h14, 2, "R9 bar1 kept");
        rd('h30, 2, "R9 rom kept");
        // R10 command overlap
        wr('h04, 0, 32'h07, "R10 cmd byte");
        wr('h03, 1, 32'h0300, "R10 straddle low");
        rd('h04, 1, "R10 cmd rb");  chk("R10 cmd literal", rsp_rdata, 32'h0003);
        wr('h06, 0, 32'h11, "R10 beside");
        wr('h02, 1, 32'hFFFF, "R10 before");
        wr('h05, 0, 32'h01, "R10 high byte");
        wr('h02, 2, 32'h0000_0000, "R10 straddle word");
        idle();
        // R11 secondary bus
        wr('h19, 0, 32'h42, "R11 byte 0x19");
        chk("R11 after 0x19", {24'd0, sec_bus}, 32'h42);
        wr('h18, 1, 32'h3700, "R11 half 0x18");
        chk("R11 after 0x18", {24'd0, sec_bus}, 32'h37);
        wr('h18, 0, 32'h99, "R11 byte 0x18");
        chk("R11 unchanged", {24'd0, sec_bus}, 32'h37);
        // R4 range limits
        rd('hFC, 2, "R4 last word");
        rd('hFD, 2, "R4 word past");
        rd('hFE, 1, "R4 last half");
        rd('hFF, 1, "R4 half past");
        rd('hFF, 0, "R4 last byte");
        rd('h40, 3, "R4 bad size");
        wr('hFD, 2, 32'hDEAD_BEEF, "R4 write past");
        wr('h40, 3, 32'hDEAD_BEEF, "R4 write bad size");
        rd('hFD, 0, "R4 no write");
        rd('h40, 2, "R4 bad size no write");
        // R5 address match
        access(0, 8'h01, MY_DF, 'h00, 2, 0, "R5 other bus");
        access(0, MY_BUS, 8'h11, 'h00, 2, 0, "R5 other devfn");
        access(1, MY_BUS, 8'h18, 'h40, 2, 32'h5555_5555, "R5 write other");
        access(1, 8'h02, MY_DF, 'h19, 0, 32'h77, "R5 bus write other");
        rd('h40, 2, "R5 untouched");
        chk("R5 sec untouched", {24'd0, sec_bus}, 32'h37);
        // back-to-back mixed sweep
        for (int k = 0; k < 16; k++) begin
            wr('h50 + k, k % 3, 32'h0102_0304 * (k + 1), "R12 sweep");
            rd('h50 + (k & 12), 2, "R3 sweep");
        end
        idle();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule